// File: doc/BRIEF.md
# Eighth-Sample Chroma Bilinear Interpolator

This block forms a motion-compensated chroma prediction tile from a stream of 8-bit reference samples. A fractional motion offset (horizontal and vertical, each in eighth-sample steps) selects four weights. Each output sample blends the four reference samples around its position. The weighted sum is rounded, scaled down by 64 and clamped to 8 bits.

A start pulse latches the tile geometry and the two offsets. Reference samples then arrive one per handshake in raster order. The block keeps the previous reference row in a small line buffer, so every row is read only once. Output samples leave in raster order through a registered valid/ready port, and the last one carries a marker.

When both offsets are zero, the block copies the input and takes no extra row or column. A one-cycle done pulse follows the acceptance of the final sample.

Top module: `chroma_bilin_interp`

## Requirements
- R1: With offsets fx = cfg_dx and fy = cfg_dy (each 0..7), the weights are wTL=(8-fx)(8-fy), wTR=fx(8-fy), wBL=(8-fx)fy and wBR=fx*fy. They sum to 64.
- R2: In interpolating mode (fx or fy nonzero), the output at row r, column c is (wTL*p[r][c] + wTR*p[r][c+1] + wBL*p[r+1][c] + wBR*p[r+1][c+1] + 32) >> 6, clamped to 0..255. Here p[i][j] is reference row i, column j.
- R3: cfg_wcode selects the tile width: 0 gives 2, 1 gives 4, 2 gives 8. The unsupported code 3 behaves as width 8.
- R4: In interpolating mode, a tile of width W and height H takes exactly (W+1)*(H+1) input samples in raster order. It produces W*H output samples in raster order. After that, in_ready stays low.
- R5: When fx and fy are both 0, the tile takes exactly W*H input samples. Each output equals the input sample at the same position.
- R6: out_last is 1 on the final output sample of the tile and 0 on every other output sample.
- R7: Configuration is captured only by a start pulse while the block is idle. A start pulse, or a change on any cfg_* port, during a tile has no effect on that tile's outputs or input count.
- R8: done is high for exactly one cycle: the cycle after the final sample is accepted on the output.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values and no input is taken. No sample is lost or duplicated under any stall pattern.
- R10: After reset, out_valid, in_ready and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a tile (used only when idle) |
| cfg_wcode | input | 2 | Width code: 0=2, 1=4, 2 or 3=8 |
| cfg_height | input | HBITS | Tile height in rows (even, nonzero) |
| cfg_dx | input | 3 | Horizontal fraction in eighths |
| cfg_dy | input | 3 | Vertical fraction in eighths |
| in_valid | input | 1 | Reference sample valid |
| in_ready | output | 1 | Block accepts a reference sample |
| in_data | input | 8 | Reference sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 8 | Interpolated sample |
| out_last | output | 1 | Final sample of the tile |
| done | output | 1 | One-cycle pulse after the tile completes |

## Verification
An output sample appears on out_data one clock edge after the input handshake that completes its 2x2 neighbourhood. done rises one edge after the final output handshake. The bench drives inputs at the falling edge and reads every port one time unit later, so each handshake it records is the one the next rising edge takes. Expected samples are compared in the order the handshakes occur, and the done check runs in the iteration that follows the final acceptance. Stall patterns on both sides shift these cycles without changing the expected sequence.

// File: rtl/chroma_interp_pkg.sv
package chroma_interp_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 3;
  localparam int WGT_W  = 7;
  localparam int SHIFT  = 6;
  localparam int ACC_W  = PIX_W + SHIFT + 1;
  localparam int TAPS   = 4;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [WGT_W-1:0] wgt_t;

  typedef struct packed {
    wgt_t tl;
    wgt_t tr;
    wgt_t bl;
    wgt_t br;
  } wset_t;

  typedef struct packed {
    pix_t tl;
    pix_t tr;
    pix_t bl;
    pix_t br;
  } quad_t;

  typedef enum logic [1:0] {
    WCODE_2   = 2'd0,
    WCODE_4   = 2'd1,
    WCODE_8   = 2'd2,
    WCODE_RSV = 2'd3
  } wcode_e;
endpackage

// File: rtl/chroma_weight_gen.sv
module chroma_weight_gen
  import chroma_interp_pkg::*;
(
  input  logic [FRAC_W-1:0] fx,
  input  logic [FRAC_W-1:0] fy,
  output wset_t             w
);
  wgt_t fx_e, fy_e, gx, gy;

  always_comb begin
    fx_e = wgt_t'(fx);
    fy_e = wgt_t'(fy);
    gx   = wgt_t'(8) - fx_e;
    gy   = wgt_t'(8) - fy_e;
    w.tl = gx * gy;
    w.tr = fx_e * gy;
    w.bl = gx * fy_e;
    w.br = fx_e * fy_e;
  end

  always_comb begin
    if (!$isunknown({fx, fy})) begin
      assert_weight_sum_R1: assert (({1'b0, w.tl} + {1'b0, w.tr} + {1'b0, w.bl} + {1'b0, w.br}) == 8'd64)
        else $error("weights do not sum to 64");
    end
  end
endmodule

// File: rtl/chroma_line_buf.sv
module chroma_line_buf
  import chroma_interp_pkg::*;
#(
  parameter int DEPTH = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pix_t          wdata,
  input  logic [AW-1:0] raddr,
  output pix_t          rdata
);
  pix_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/chroma_bilin_mac.sv
module chroma_bilin_mac
  import chroma_interp_pkg::*;
(
  input  quad_t q,
  input  wset_t w,
  output pix_t  y
);
  pix_t             px [TAPS];
  wgt_t             wt [TAPS];
  logic [ACC_W-1:0] prod [TAPS];
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] scaled;

  always_comb begin
    px[0] = q.tl; px[1] = q.tr; px[2] = q.bl; px[3] = q.br;
    wt[0] = w.tl; wt[1] = w.tr; wt[2] = w.bl; wt[3] = w.br;
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign prod[i] = ACC_W'(px[i]) * ACC_W'(wt[i]);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + prod[i];
    scaled = (acc + ACC_W'(32)) >> SHIFT;
    y = (scaled > ACC_W'(255)) ? pix_t'(255) : scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/chroma_bilin_interp.sv
module chroma_bilin_interp
  import chroma_interp_pkg::*;
#(
  parameter int MAX_W = 8,
  parameter int HBITS = 5,
  localparam int LB_DEPTH = MAX_W + 1,
  localparam int CW       = $clog2(LB_DEPTH),
  localparam int RW       = HBITS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       cfg_wcode,
  input  logic [HBITS-1:0] cfg_height,
  input  logic [2:0]       cfg_dx,
  input  logic [2:0]       cfg_dy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             done
);
  logic             busy, in_fin, copy_q;
  logic [2:0]       dx_q, dy_q;
  logic [CW-1:0]    w_q, col, ncols;
  logic [HBITS-1:0] h_q;
  logic [RW-1:0]    row, nrows;
  pix_t             left_q, upleft_q, up_rd, mac_y;
  wset_t            wts;
  quad_t            quad;
  logic             fire, emit, end_col, end_row;
  logic [CW-1:0]    w_sel;

  always_comb begin
    case (wcode_e'(cfg_wcode))
      WCODE_2: w_sel = CW'(2);
      WCODE_4: w_sel = CW'(4);
      default: w_sel = CW'(8);
    endcase
  end

  assign ncols    = copy_q ? w_q : w_q + CW'(1);
  assign nrows    = copy_q ? {1'b0, h_q} : {1'b0, h_q} + RW'(1);
  assign in_ready = busy & ~in_fin & (~out_valid | out_ready);
  assign fire     = in_valid & in_ready;
  assign end_col  = (col == ncols - CW'(1));
  assign end_row  = (row == nrows - RW'(1));
  assign emit     = copy_q | ((row != '0) & (col != '0));

  chroma_weight_gen u_wgen (
    .fx (dx_q),
    .fy (dy_q),
    .w  (wts)
  );

  chroma_line_buf #(.DEPTH(LB_DEPTH)) u_lbuf (
    .clk   (clk),
    .we    (fire),
    .waddr (col),
    .wdata (in_data),
    .raddr (col),
    .rdata (up_rd)
  );

  assign quad = '{tl: upleft_q, tr: up_rd, bl: left_q, br: in_data};

  chroma_bilin_mac u_mac (
    .q (quad),
    .w (wts),
    .y (mac_y)
  );

  // configuration capture and sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      in_fin <= 1'b0;
      copy_q <= 1'b0;
      dx_q   <= '0;
      dy_q   <= '0;
      w_q    <= CW'(2);
      h_q    <= '0;
      col    <= '0;
      row    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          in_fin <= 1'b0;
          dx_q   <= cfg_dx;
          dy_q   <= cfg_dy;
          copy_q <= (cfg_dx == 3'd0) && (cfg_dy == 3'd0);
          w_q    <= w_sel;
          h_q    <= cfg_height;
          col    <= '0;
          row    <= '0;
        end
      end else begin
        if (fire) begin
          if (end_col) begin
            col <= '0;
            row <= row + RW'(1);
            if (end_row) in_fin <= 1'b1;
          end else begin
            col <= col + CW'(1);
          end
        end
        if (out_valid && out_ready && out_last) begin
          busy   <= 1'b0;
          in_fin <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // neighbour registers
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      upleft_q <= '0;
    end else if (fire) begin
      left_q   <= in_data;
      upleft_q <= up_rd;
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (fire && emit) begin
      out_valid <= 1'b1;
      out_data  <= copy_q ? in_data : mac_y;
      out_last  <= end_col && end_row;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
    else $error("output changed while stalled");

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_last_then_done_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> done)
    else $error("done missing after final sample");

  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(dx_q) && $stable(dy_q) && $stable(w_q) && $stable(h_q)))
    else $error("configuration changed during a tile");
endmodule

// File: tb/chroma_bilin_interp_bench.sv
module chroma_bilin_interp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    cfg_wcode = '0;
  logic [HB-1:0] cfg_height = '0;
  logic [2:0]    cfg_dx = '0, cfg_dy = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          out_last;
  logic          done;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] sin  [0:199];
  logic [7:0] sexp [0:199];

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_bilin_interp #(.MAX_W(8), .HBITS(HB)) u_chroma_bilin_interp (
    .clk(clk), .rst(rst), .start(start), .cfg_wcode(cfg_wcode),
    .cfg_height(cfg_height), .cfg_dx(cfg_dx), .cfg_dy(cfg_dy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int refpix(input int seed, input int r, input int c);
    if (seed == 1000) return 255;
    if (seed == 1001) return 0;
    return (seed * 53 + r * 29 + c * 71 + r * c * 13 + (r ^ c) * 7) & 255;
  endfunction

  task automatic run_block(input int wc, input int h, input int fx, input int fy,
                           input int seed, input int mode, input bit disturb);
    int w, nc, nr, n_in, n_out, in_idx, out_idx, cyc;
    bit cp, pend, fin;
    int wa, wb, wcc, wd, acc, v;
    string rq;
    w  = (wc == 0) ? 2 : (wc == 1) ? 4 : 8;
    cp = (fx == 0) && (fy == 0);
    nc = cp ? w : w + 1;
    nr = cp ? h : h + 1;
    n_in  = nc * nr;
    n_out = w * h;
    wa = (8 - fx) * (8 - fy); wb = fx * (8 - fy); wcc = (8 - fx) * fy; wd = fx * fy;
    for (int r = 0; r < nr; r++)
      for (int c = 0; c < nc; c++) sin[r * nc + c] = 8'(refpix(seed, r, c));
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        if (cp) v = refpix(seed, r, c);
        else begin
          acc = wa * refpix(seed, r, c) + wb * refpix(seed, r, c + 1)
              + wcc * refpix(seed, r + 1, c) + wd * refpix(seed, r + 1, c + 1);
          v = (acc + 32) >> 6;
          if (v > 255) v = 255;
        end
        sexp[r * w + c] = 8'(v);
      end
    rq = cp ? "R5" : "R1 R2";

    @(negedge clk);
    start = 1'b1; cfg_wcode = 2'(wc); cfg_height = HB'(h);
    cfg_dx = 3'(fx); cfg_dy = 3'(fy);
    @(negedge clk);
    start = 1'b0;
    in_idx = 0; out_idx = 0; pend = 0; fin = 0; cyc = 0;
    while (!fin) begin
      if (disturb && cyc == 3) begin
        start = 1'b1; cfg_wcode = 2'(wc + 1); cfg_height = HB'(h + 2);
        cfg_dx = 3'(fx + 3); cfg_dy = 3'(fy + 5);
      end else start = 1'b0;
      case (mode)
        0: begin out_ready = 1'b1; in_valid = 1'b1; end
        1: begin out_ready = ((cyc * 7 + 3) % 5) != 0; in_valid = (cyc % 4) != 1; end
        default: begin out_ready = (cyc % 3) == 0; in_valid = (cyc % 2) == 0; end
      endcase
      in_data = (in_idx < n_in) ? sin[in_idx] : 8'hA5;
      #1;
      if (pend) begin
        chk(done === 1'b1, "R8", "done after final accept", int'(done), 1);
        fin = 1;
      end else if (done === 1'b1) chk(1'b0, "R8", "spurious done", 1, 0);
      if (in_valid && in_ready) begin
        if (in_idx >= n_in) chk(1'b0, cp ? "R5" : "R4", "extra input taken", in_idx + 1, n_in);
        in_idx++;
      end
      if (out_valid && out_ready) begin
        if (out_idx < n_out) begin
          chk(out_data === sexp[out_idx], rq, "sample value", int'(out_data), int'(sexp[out_idx]));
          chk(out_last === (out_idx == n_out - 1), "R6", "last flag",
              int'(out_last), int'(out_idx == n_out - 1));
        end else chk(1'b0, "R4", "extra output", out_idx + 1, n_out);
        if (out_idx == n_out - 1) pend = 1;
        out_idx++;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 3000) begin
        chk(1'b0, "R4", "tile stuck, outputs seen", out_idx, n_out);
        fin = 1;
      end
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(in_idx == n_in, disturb ? "R7" : (cp ? "R5" : "R4"), "input count", in_idx, n_in);
    chk(out_idx == n_out, wc == 3 ? "R3" : "R4", "output count", out_idx, n_out);
    chk(in_ready === 1'b0 && out_valid === 1'b0, "R4", "idle after tile",
        int'({in_ready, out_valid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b0 && done === 1'b0, "R10",
        "reset outputs", int'({out_valid, in_ready, done}), 0);
    rst = 1'b0;
    // sweep every fraction pair over the three widths
    for (int wc = 0; wc < 3; wc++)
      for (int fx = 0; fx < 8; fx++)
        for (int fy = 0; fy < 8; fy++)
          run_block(wc, 2 + 2 * ((fx + fy) & 1), fx, fy, wc * 64 + fx * 8 + fy,
                    (fx + fy + wc) % 3, 1'b0);
    run_block(3, 4, 3, 5, 7, 1, 1'b0);      // R3 reserved code
    run_block(3, 2, 0, 0, 9, 2, 1'b0);      // R3 with copy
    run_block(2, 2, 7, 7, 1000, 1, 1'b0);   // R2 ceiling
    run_block(1, 4, 5, 2, 1001, 0, 1'b0);   // R2 floor
    run_block(2, 16, 2, 6, 11, 2, 1'b0);    // tall tile, heavy stalls R9
    run_block(1, 4, 4, 1, 13, 1, 1'b1);     // R7 start and cfg change mid-tile
    run_block(0, 6, 0, 0, 17, 1, 1'b1);     // R7 in copy mode
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule